// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block is a synthesizable model of a small synchronous burst SRAM. Each word holds four byte lanes, and each lane is 8 data bits plus 1 parity bit. An access opens on a clock edge where one of two address strobes is low and the chip enables select the part. The processor-side strobe always opens a read. The controller-side strobe opens a read or a write, depending on the write controls. While a burst is open and no strobe is low, each edge either steps a 2-bit burst counter or holds it, as the advance input directs. Each such edge performs one more read or write at the resulting address, and the address stays inside the aligned 4-word block that the start address belongs to.

Writes are decoded from a global write, a byte-write enable and one select per lane. Read data comes from a register: it appears on the output pins one edge after the address is used. The output enable is not clocked. It gates the data-bus drive combinationally, and the drive is forced off in any cycle that is about to write. The shared data bus is modelled as separate in, out and output-enable ports.

Top module: `sync_burst_sram`

## Requirements
- R1: An edge with `ads_proc_n` low and the chip selected opens a read at `addr` and writes nothing. This holds whatever the levels of `gw_n`, `bwe_n`, `bw_n` and `ads_ctrl_n` are.
- R2: An edge with `ads_ctrl_n` low (`ads_proc_n` high), the chip selected and the write condition true writes `dq_in` into the word at `addr`.
- R3: When `gw_n` is low in a write-capable cycle, all four lanes are written, and `bwe_n` and `bw_n` have no effect.
- R4: When `gw_n` is high and `bwe_n` is low, each lane whose `bw_n` bit is low is written, parity bit included, and every other lane keeps its contents. Lane i occupies `dq` bits [9i+8:9i], and its parity is bit 9i+8.
- R5: When `gw_n` is high and `bwe_n` is high, the cycle is a read, even if some `bw_n` bits are low.
- R6: On an edge where both strobes are high, a burst is open and `adv_n` is low, the burst counter steps by one. With `burst_order`=0 the word used has low address bits (start + count) mod 4, and the upper bits stay those of the start address.
- R7: With `burst_order`=1 the low address bits of the word used are start XOR count.
- R8: On an edge where both strobes are high, a burst is open and `adv_n` is high, the counter holds and the same word is accessed again.
- R9: The chip is selected when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 on a strobe edge. A strobe edge without selection begins no access, closes any open burst, and leaves later strobe-free cycles without effect until the next selected strobe.
- R10: The data of a read at edge k is on `dq_out` from edge k until the next read edge. Before edge k, `dq_out` still shows the earlier value.
- R11: `dq_oe` is high only while the last access edge was a read, `oe_n` is low, and the current inputs do not form a write cycle. A change of `oe_n` takes effect without a clock edge.
- R12: After reset, `dq_oe` is low and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Start address, taken on a strobe edge |
| ads_proc_n | input | 1 | Processor-side address strobe, active low, always a read |
| ads_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high holds the counter |
| gw_n | input | 1 | Global write, active low, all lanes |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_order | input | 1 | 0 linear burst, 1 interleaved burst |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Bus drive enable for dq_out |

## Verification
The hardest state to reach is a burst that wraps at the block boundary while the output drive must drop for a pending write. The counter only moves on strobe-free edges, and its value is visible only through the data it addresses. To reach this state, the stimulus first fills one aligned block with a single controller strobe followed by three advance writes. It then reads that block back from a mid-block start in linear order, in interleaved order and with a suspend, so that every wrap step shows up as a distinct word on `dq_out`. A write-form input pattern is held briefly inside an open read burst to show that the drive drops without a clock edge.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  localparam int unsigned BURST_W = 2;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  // Word offset inside the 4-word block for a given burst step.
  function automatic logic [BURST_W-1:0] burst_offset(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] step,
    input logic               interleave
  );
    logic [BURST_W-1:0] r;
    if (interleave) r = start ^ step;
    else            r = start + step;
    return r;
  endfunction

endpackage

// File: rtl/sbsram_wr_decode.sv
module sbsram_wr_decode #(
  parameter int unsigned LANES = 4
) (
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic             wr_cond,
  output logic [LANES-1:0] lane_sel
);

  // Global write overrides the per-lane hierarchy entirely.
  always_comb begin
    if (!gw_n) begin
      lane_sel = '1;
    end else if (!bwe_n) begin
      lane_sel = ~bw_n;
    end else begin
      lane_sel = '0;
    end
    wr_cond = |lane_sel;
  end

endmodule

// File: rtl/sbsram_burst_ctl.sv
module sbsram_burst_ctl
  import sbsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ads_proc_n,
  input  logic              ads_ctrl_n,
  input  logic              adv_n,
  input  logic              chip_sel,
  input  logic              interleave,
  input  logic              wr_cond,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] acc_addr,
  output acc_kind_e         acc_kind,
  output logic              active,
  output logic [BURST_W-1:0] step
);

  localparam int unsigned HI_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] step_q;
  logic [BURST_W-1:0] step_nxt;
  logic               active_q;
  logic               strobe;

  assign strobe = !ads_proc_n || !ads_ctrl_n;
  assign step_nxt = adv_n ? step_q : step_q + BURST_W'(1);

  always_comb begin
    acc_addr = addr;
    acc_kind = ACC_NONE;
    if (strobe) begin
      if (chip_sel) begin
        acc_addr = addr;
        if (!ads_proc_n)   acc_kind = ACC_READ;
        else if (wr_cond)  acc_kind = ACC_WRITE;
        else               acc_kind = ACC_READ;
      end
    end else if (active_q) begin
      acc_addr = {base_q[ADDR_W-1 -: HI_W],
                  burst_offset(base_q[BURST_W-1:0], step_nxt, interleave)};
      acc_kind = wr_cond ? ACC_WRITE : ACC_READ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      step_q   <= '0;
    end else if (strobe) begin
      active_q <= chip_sel;
      base_q   <= addr;
      step_q   <= '0;
    end else if (active_q) begin
      step_q   <= step_nxt;
    end
  end

  assign active = active_q;
  assign step   = step_q;

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rd_en,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (lane_we[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en)      rd_q        <= cells[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ads_proc_n,
  input  logic                    ads_ctrl_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    oe_n,
  input  logic                    burst_order,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);

  logic               chip_sel;
  logic               wr_cond;
  logic [LANES-1:0]   lane_sel;
  logic [LANES-1:0]   lane_we;
  logic [ADDR_W-1:0]  acc_addr;
  acc_kind_e          acc_kind;
  logic               active;
  logic [BURST_W-1:0] step;
  logic               wr_en;
  logic               rd_en;
  logic               rd_valid_q;

  assign chip_sel = !ce1_n && ce2 && !ce3_n;

  sbsram_wr_decode #(.LANES(LANES)) u_dec (
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .bw_n     (bw_n),
    .wr_cond  (wr_cond),
    .lane_sel (lane_sel)
  );

  sbsram_burst_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .adv_n      (adv_n),
    .chip_sel   (chip_sel),
    .interleave (burst_order),
    .wr_cond    (wr_cond),
    .addr       (addr),
    .acc_addr   (acc_addr),
    .acc_kind   (acc_kind),
    .active     (active),
    .step       (step)
  );

  assign wr_en   = (acc_kind == ACC_WRITE);
  assign rd_en   = (acc_kind == ACC_READ);
  assign lane_we = wr_en ? lane_sel : '0;

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk     (clk),
    .rd_en   (rd_en),
    .lane_we (lane_we),
    .addr    (acc_addr),
    .wdata   (dq_in),
    .rdata   (dq_out)
  );

  // Tracks whether the most recent access edge left read data in the register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rd_valid_q <= 1'b0;
    else if (acc_kind != ACC_NONE)  rd_valid_q <= rd_en;
    else if (ads_proc_n == 1'b0 || ads_ctrl_n == 1'b0) rd_valid_q <= 1'b0;
  end

  // Output enable is combinational and masked while a write is pending.
  assign dq_oe = rd_valid_q && !oe_n && !wr_en;

endmodule

// File: rtl/sbsram_checker.sv
module sbsram_checker #(
  parameter int unsigned LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ads_proc_n,
  input logic             ads_ctrl_n,
  input logic             adv_n,
  input logic             gw_n,
  input logic             bwe_n,
  input logic             ce1_n,
  input logic             ce2,
  input logic             ce3_n,
  input logic             oe_n,
  input logic             dq_oe,
  input logic             active,
  input logic [1:0]       step,
  input logic             rd_valid,
  input logic             wr_en,
  input logic [LANES-1:0] lane_we
);

  logic sel_m;
  logic quiet_m;
  assign sel_m   = !ce1_n && ce2 && !ce3_n;
  assign quiet_m = ads_proc_n && ads_ctrl_n;

  assert_proc_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_proc_n |-> (!wr_en && lane_we == '0));

  assert_proc_opens_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_proc_n && sel_m) |=> rd_valid);

  assert_global_all_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !gw_n) |-> (&lane_we));

  assert_bwe_high_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n && bwe_n) |-> !wr_en);

  assert_step_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_m && active && !adv_n) |=> (step == 2'($past(step) + 2'd1)));

  assert_step_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_m && active && adv_n) |=> $stable(step));

  assert_deselect_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!quiet_m && !sel_m) |=> (!active && !rd_valid));

  assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_m && !active) |-> !wr_en);

  assert_drive_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !oe_n && !wr_en) |-> dq_oe);

  assert_oe_gates_R11: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  assert_write_masks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !dq_oe);

endmodule

bind sync_burst_sram sbsram_checker #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ads_proc_n (ads_proc_n),
  .ads_ctrl_n (ads_ctrl_n),
  .adv_n      (adv_n),
  .gw_n       (gw_n),
  .bwe_n      (bwe_n),
  .ce1_n      (ce1_n),
  .ce2        (ce2),
  .ce3_n      (ce3_n),
  .oe_n       (oe_n),
  .dq_oe      (dq_oe),
  .active     (active),
  .step       (step),
  .rd_valid   (rd_valid_q),
  .wr_en      (wr_en),
  .lane_we    (lane_we)
);

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;

  typedef struct packed {
    logic          gw_n;
    logic          bwe_n;
    logic [3:0]    bw_n;
    logic [DW-1:0] wdata;
    logic [DW-1:0] expect_q;
  } vec_t;

  // Cumulative writes to one word; each row is followed by a read-back.
  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b1, 4'hF, 36'h0_0000_0000, 36'h0_0000_0000},
    '{1'b1, 1'b0, 4'hE, 36'hF_FFFF_FFFF, 36'h0_0000_01FF},
    '{1'b1, 1'b0, 4'h7, 36'hF_FFFF_FFFF, 36'hF_F800_01FF},
    '{1'b1, 1'b1, 4'h0, 36'h0_0000_0000, 36'hF_F800_01FF},
    '{1'b0, 1'b0, 4'hF, 36'h9_8765_4321, 36'h9_8765_4321},
    '{1'b1, 1'b0, 4'hA, 36'h0_0000_0000, 36'h9_8001_4200}
  };

  localparam logic [DW-1:0] D0 = 36'hA_0000_0001;
  localparam logic [DW-1:0] D1 = 36'hB_0000_0010;
  localparam logic [DW-1:0] D2 = 36'hC_0000_0100;
  localparam logic [DW-1:0] D3 = 36'hD_0000_1000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              ads_proc_n = 1'b1;
  logic              ads_ctrl_n = 1'b1;
  logic              adv_n = 1'b1;
  logic              gw_n = 1'b1;
  logic              bwe_n = 1'b1;
  logic [LANES-1:0]  bw_n = '1;
  logic              ce1_n = 1'b0;
  logic              ce2 = 1'b1;
  logic              ce3_n = 1'b0;
  logic              oe_n = 1'b0;
  logic              burst_order = 1'b0;
  logic [DW-1:0]     dq_in = '0;
  logic [DW-1:0]     dq_out;
  logic              dq_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sync_burst_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ads_proc_n(ads_proc_n),
    .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .oe_n(oe_n),
    .burst_order(burst_order), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    ads_proc_n = 1'b1; ads_ctrl_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
  endtask

  task automatic ctrl_write(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d,
                            input logic g, input logic b, input logic [3:0] bw);
    addr = a; dq_in = d; gw_n = g; bwe_n = b; bw_n = bw; ads_ctrl_n = 1'b0;
    tick();
    quiet();
  endtask

  task automatic proc_read(input logic [ADDR_W-1:0] a, output logic [DW-1:0] d);
    addr = a; ads_proc_n = 1'b0;
    tick();
    d = dq_out;
    quiet();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    @(negedge clk);
    // R12: reset state
    check("R12 dq_oe in reset", {35'd0, dq_oe}, 36'd0);
    tick();
    rst_n = 1'b1;
    tick();
    check("R12 dq_oe after reset", {35'd0, dq_oe}, 36'd0);

    // R2 R3 R4 R5: table of write/read-back vectors
    for (int i = 0; i < 6; i++) begin
      ctrl_write(6'd9, VECS[i].wdata, VECS[i].gw_n, VECS[i].bwe_n, VECS[i].bw_n);
      proc_read(6'd9, rd);
      check($sformatf("R2/R3/R4/R5 vector %0d", i), rd, VECS[i].expect_q);
    end

    // R6: burst write from 14 wraps linearly to 15, 12, 13
    addr = 6'd14; dq_in = D0; gw_n = 1'b0; ads_ctrl_n = 1'b0;
    tick();
    ads_ctrl_n = 1'b1; adv_n = 1'b0;
    dq_in = D1; tick();
    dq_in = D2; tick();
    dq_in = D3; tick();
    quiet();
    proc_read(6'd12, rd); check("R6 wrap word 12", rd, D2);
    proc_read(6'd13, rd); check("R6 wrap word 13", rd, D3);
    proc_read(6'd14, rd); check("R6 start word 14", rd, D0);
    proc_read(6'd15, rd); check("R6 word 15", rd, D1);

    // R6: linear burst read from 13: 13,14,15,12
    addr = 6'd13; ads_proc_n = 1'b0; tick();
    check("R6 linear step0", dq_out, D3);
    ads_proc_n = 1'b1; adv_n = 1'b0;
    tick(); check("R6 linear step1", dq_out, D0);
    tick(); check("R6 linear step2", dq_out, D1);
    tick(); check("R6 linear step3 wrap", dq_out, D2);
    quiet();

    // R7: interleaved burst read from 13: 13,12,15,14
    burst_order = 1'b1;
    addr = 6'd13; ads_proc_n = 1'b0; tick();
    check("R7 interleave step0", dq_out, D3);
    ads_proc_n = 1'b1; adv_n = 1'b0;
    tick(); check("R7 interleave step1", dq_out, D2);
    tick(); check("R7 interleave step2", dq_out, D1);
    tick(); check("R7 interleave step3", dq_out, D0);
    quiet();
    burst_order = 1'b0;

    // R8: suspend holds the word, then advance resumes
    addr = 6'd12; ads_proc_n = 1'b0; tick();
    ads_proc_n = 1'b1; adv_n = 1'b1;
    tick(); check("R8 suspend same word", dq_out, D2);
    adv_n = 1'b0;
    tick(); check("R8 resume next word", dq_out, D3);

    // R11: write-form inputs inside open read burst drop drive at once
    adv_n = 1'b1;
    check("R11 drive during read", {35'd0, dq_oe}, 36'd1);
    gw_n = 1'b0; #1;
    check("R11 write pending masks drive", {35'd0, dq_oe}, 36'd0);
    gw_n = 1'b1; #1;
    oe_n = 1'b1; #1;
    check("R11 oe_n high no drive", {35'd0, dq_oe}, 36'd0);
    oe_n = 1'b0; #1;
    check("R11 oe_n low drives", {35'd0, dq_oe}, 36'd1);
    @(negedge clk);
    quiet();

    // R10: read data appears after the edge, not before
    proc_read(6'd15, rd);
    addr = 6'd14; ads_proc_n = 1'b0; #1;
    check("R10 before edge old data", dq_out, D1);
    tick();
    check("R10 after edge new data", dq_out, D0);
    quiet();

    // R1: processor strobe with global write low stays a read
    addr = 6'd12; dq_in = 36'h5_5555_5555; gw_n = 1'b0; ads_proc_n = 1'b0;
    tick();
    check("R1 proc strobe returns old data", dq_out, D2);
    quiet();
    proc_read(6'd12, rd); check("R1 word 12 unchanged", rd, D2);
    // R1: both strobes low, processor side wins
    addr = 6'd13; dq_in = 36'h5_5555_5555; gw_n = 1'b0;
    ads_proc_n = 1'b0; ads_ctrl_n = 1'b0;
    tick();
    quiet();
    proc_read(6'd13, rd); check("R1 both strobes no write", rd, D3);

    // R9: deselected strobe begins nothing, later quiet writes ignored
    ce2 = 1'b0;
    addr = 6'd14; dq_in = 36'h7_7777_7777; gw_n = 1'b0; ads_ctrl_n = 1'b0;
    tick();
    check("R9 no drive after deselect", {35'd0, dq_oe}, 36'd0);
    ads_ctrl_n = 1'b1; adv_n = 1'b0; ce2 = 1'b1;
    tick();
    quiet();
    proc_read(6'd14, rd); check("R9 word 14 unchanged", rd, D0);
    proc_read(6'd15, rd); check("R9 word 15 unchanged", rd, D1);
    ce3_n = 1'b1;
    addr = 6'd12; ads_proc_n = 1'b0;
    tick();
    check("R9 deselected proc read no drive", {35'd0, dq_oe}, 36'd0);
    quiet();
    ce3_n = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule